// File: doc/BRIEF.md
# Power Mode and Reset-Cause Controller

This block keeps a coded record of why the system last went through reset and steps the system through its low-power states. Software reaches it through a single 8-bit register on a simple write-strobe bus, with a read port that always shows the register's current value. Five reset-event inputs report a reset from power-on, the supply monitor, the key, the low-voltage detector or the watchdog. A sixth cause, the software reset, comes from the register itself. The register holds a 3-bit code for the newest cause.

Writing the mode bits raises one of three level requests: idle, standby or sleep. The request stays up until a wake event arrives. Idle ends at once. Sleep and standby end at once when the recovery-mode bit is set. When that bit is clear, they wait through a settle interval of WAKE_DELAY_CYCLES clocks, the count that stands for 8 ms, before the wake-complete pulse. A software-reset write produces a one-cycle reset pulse for the rest of the chip.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous power-on reset (porN low), rdData reads 0x00 and idleReq, standbyReq, sleepReq, softRst and wakeDone are all low.
- R2: A reset event on srcEvt[i] loads code i into rdData[7:5] on the next clock. The codes are 0 power-on, 1 supply monitor, 2 key, 3 low voltage and 4 watchdog. The code holds until another reset event occurs.
- R3: When several srcEvt bits are high in the same cycle, the lowest index is recorded, so power-on always wins.
- R4: A write with wrData[4]=1 raises softRst for exactly the next cycle and records code 5 in rdData[7:5]. If an srcEvt bit is high in the same cycle, that lower code is recorded instead. rdData[4] always reads 0.
- R5: rdData[3] is the recovery-mode bit. It is loaded from wrData[3] on every write and resets to 0.
- R6: When no mode is active, writing wrData[2], wrData[1] or wrData[0] as 1 raises sleepReq, standbyReq or idleReq from the next cycle. The request stays high until it ends, and rdData[2:0] always reads 0.
- R7: When a single write sets several mode bits, sleep beats standby and standby beats idle. At most one request is high at a time.
- R8: A mode write that arrives while a request or a wake wait is active is ignored.
- R9: A wakeEvt during idle drops idleReq on the next cycle and pulses wakeDone for that one cycle, whatever the recovery-mode bit holds.
- R10: A wakeEvt during sleep or standby with the recovery-mode bit at 1 drops the request and pulses wakeDone on the next cycle.
- R11: A wakeEvt during sleep or standby with the recovery-mode bit at 0 drops the request on the next cycle. wakeDone then pulses once, exactly WAKE_DELAY_CYCLES cycles later than it would in immediate mode.
- R12: Any reset event (an srcEvt bit or a software-reset write) returns the block to running. It cancels any request or wake wait without a wakeDone pulse and clears the recovery-mode bit. A mode write made together with a software reset is ignored.
- R13: A wakeEvt while no mode is active has no effect, and wakeDone stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| srcEvt | input | 5 | Reset events, bit i is cause code i |
| wakeEvt | input | 1 | Wake event |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| idleReq | output | 1 | Idle mode request |
| standbyReq | output | 1 | Standby mode request |
| sleepReq | output | 1 | Sleep mode request |
| softRst | output | 1 | One-cycle software reset pulse |
| wakeDone | output | 1 | One-cycle wake-complete pulse |

## Verification
A wrong cause or recovery-mode value shows on rdData on the clock right after the event or write. A broken priority encoder or priority chain therefore appears within one cycle, whether it is in the cause encoder or in the mode priority. A bad mode state shows as the wrong request level one cycle after the write or wake. A settle counter that is off by any amount moves the wakeDone pulse away from the one exact cycle the bench samples on either side. A reset event that fails to cancel a wait shows up as a stray wakeDone at the end of the interval.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int SRC_COUNT = 5;
  localparam int CAUSE_W   = $clog2(SRC_COUNT + 1);
  localparam int REG_W     = 8;

  localparam int BIT_IDLE  = 0;
  localparam int BIT_STBY  = 1;
  localparam int BIT_SLEEP = 2;
  localparam int BIT_REC   = 3;
  localparam int BIT_SOFT  = 4;
  localparam int CAUSE_LSB = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_SOFT = CAUSE_W'(SRC_COUNT);

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_STBY,
    ST_SLEEP,
    ST_SETTLE
  } pwrState_t;

  typedef struct packed {
    logic wipe;
    logic softHit;
    logic recWr;
    logic recVal;
    logic cntLoad;
    logic cntRun;
  } dpStrobe_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int WAKE_DELAY_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic [SRC_COUNT-1:0] srcEvt,
  input  dpStrobe_t            strb,
  output logic [CAUSE_W-1:0]   causeQ,
  output logic                 recMode,
  output logic                 cntDone
);

  localparam int CNT_W = (WAKE_DELAY_CYCLES > 1) ? $clog2(WAKE_DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_DELAY_CYCLES - 1);

  logic [CAUSE_W-1:0] lowestCode;
  logic               anySrc;
  logic [CNT_W-1:0]   settleCnt;

  // lowest set index wins: scan from the top so lower indices overwrite
  always_comb begin
    lowestCode = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (srcEvt[i]) lowestCode = CAUSE_W'(i);
    end
  end

  assign anySrc = |srcEvt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      causeQ <= '0;
    end else if (anySrc) begin
      causeQ <= lowestCode;
    end else if (strb.softHit) begin
      causeQ <= CAUSE_SOFT;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      recMode <= 1'b0;
    end else if (strb.wipe) begin
      recMode <= 1'b0;
    end else if (strb.recWr) begin
      recMode <= strb.recVal;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      settleCnt <= '0;
    end else if (strb.cntLoad) begin
      settleCnt <= '0;
    end else if (strb.cntRun && !cntDone) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign cntDone = (settleCnt == CNT_LAST);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             srcAny,
  input  logic             wakeEvt,
  input  logic             recMode,
  input  logic             cntDone,
  output dpStrobe_t        strb,
  output logic             idleReq,
  output logic             standbyReq,
  output logic             sleepReq,
  output logic             softRst,
  output logic             wakeDone
);

  pwrState_t state, stateNxt;
  logic      softHit;
  logic      wipe;
  logic      doneNxt;
  logic      loadNxt;

  assign softHit = wrEn && wrData[BIT_SOFT];
  assign wipe    = srcAny || softHit;

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    loadNxt  = 1'b0;
    if (wipe) begin
      stateNxt = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (wrEn) begin
            if (wrData[BIT_SLEEP])     stateNxt = ST_SLEEP;
            else if (wrData[BIT_STBY]) stateNxt = ST_STBY;
            else if (wrData[BIT_IDLE]) stateNxt = ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (wakeEvt) begin
            stateNxt = ST_RUN;
            doneNxt  = 1'b1;
          end
        end
        ST_STBY, ST_SLEEP: begin
          if (wakeEvt) begin
            if (recMode) begin
              stateNxt = ST_RUN;
              doneNxt  = 1'b1;
            end else begin
              stateNxt = ST_SETTLE;
              loadNxt  = 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (cntDone) begin
            stateNxt = ST_RUN;
            doneNxt  = 1'b1;
          end
        end
        default: stateNxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state    <= ST_RUN;
      wakeDone <= 1'b0;
      softRst  <= 1'b0;
    end else begin
      state    <= stateNxt;
      wakeDone <= doneNxt;
      softRst  <= softHit;
    end
  end

  always_comb begin
    strb.wipe    = wipe;
    strb.softHit = softHit;
    strb.recWr   = wrEn;
    strb.recVal  = wrData[BIT_REC];
    strb.cntLoad = loadNxt;
    strb.cntRun  = (state == ST_SETTLE);
  end

  assign idleReq    = (state == ST_IDLE);
  assign standbyReq = (state == ST_STBY);
  assign sleepReq   = (state == ST_SLEEP);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int WAKE_DELAY_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic [SRC_COUNT-1:0] srcEvt,
  input  logic                 wakeEvt,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 idleReq,
  output logic                 standbyReq,
  output logic                 sleepReq,
  output logic                 softRst,
  output logic                 wakeDone
);

  dpStrobe_t          strb;
  logic [CAUSE_W-1:0] causeQ;
  logic               recMode;
  logic               cntDone;

  pwr_mode_ctl u_ctl (
    .clk        (clk),
    .porN       (porN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .srcAny     (|srcEvt),
    .wakeEvt    (wakeEvt),
    .recMode    (recMode),
    .cntDone    (cntDone),
    .strb       (strb),
    .idleReq    (idleReq),
    .standbyReq (standbyReq),
    .sleepReq   (sleepReq),
    .softRst    (softRst),
    .wakeDone   (wakeDone)
  );

  pwr_mode_dp #(
    .WAKE_DELAY_CYCLES (WAKE_DELAY_CYCLES)
  ) u_dp (
    .clk     (clk),
    .porN    (porN),
    .srcEvt  (srcEvt),
    .strb    (strb),
    .causeQ  (causeQ),
    .recMode (recMode),
    .cntDone (cntDone)
  );

  always_comb begin
    rdData = '0;
    rdData[CAUSE_LSB +: CAUSE_W] = causeQ;
    rdData[BIT_REC]              = recMode;
  end

endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
(
  input logic                 clk,
  input logic                 porN,
  input logic [SRC_COUNT-1:0] srcEvt,
  input logic                 wakeEvt,
  input logic                 wrEn,
  input logic [REG_W-1:0]     wrData,
  input logic [REG_W-1:0]     rdData,
  input logic                 idleReq,
  input logic                 standbyReq,
  input logic                 sleepReq,
  input logic                 softRst,
  input logic                 wakeDone
);

  logic softW;
  logic quiet;
  assign softW = wrEn && wrData[BIT_SOFT];
  assign quiet = (srcEvt == '0) && !softW;

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!porN)
    $onehot0({idleReq, standbyReq, sleepReq})); // R7

  AST_SOFT_RAISE: assert property (@(posedge clk) disable iff (!porN)
    softW |=> softRst); // R4

  AST_SOFT_SINGLE: assert property (@(posedge clk) disable iff (!porN)
    !softW |=> !softRst); // R4

  AST_SOFT_CODE: assert property (@(posedge clk) disable iff (!porN)
    (softW && srcEvt == '0) |=> (rdData[7:5] == 3'd5)); // R4

  AST_POR_WINS: assert property (@(posedge clk) disable iff (!porN)
    srcEvt[0] |=> (rdData[7:5] == 3'd0)); // R3

  AST_EVT_CANCEL: assert property (@(posedge clk) disable iff (!porN)
    (|srcEvt) |=> (!idleReq && !standbyReq && !sleepReq && !wakeDone && !rdData[3])); // R12

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!porN)
    (idleReq && wakeEvt && quiet) |=> (wakeDone && !idleReq)); // R9

  AST_FAST_WAKE: assert property (@(posedge clk) disable iff (!porN)
    ((sleepReq || standbyReq) && wakeEvt && rdData[3] && quiet) |=> wakeDone); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!porN)
    wakeDone |=> !wakeDone); // R11

endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (.*);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int DLY = 20;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [4:0] srcEvt = '0;
  logic       wakeEvt = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       idleReq, standbyReq, sleepReq, softRst, wakeDone;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.WAKE_DELAY_CYCLES(DLY)) u_pwr_mode_ctrl (
    .clk(clk), .porN(porN), .srcEvt(srcEvt), .wakeEvt(wakeEvt),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .idleReq(idleReq), .standbyReq(standbyReq), .sleepReq(sleepReq),
    .softRst(softRst), .wakeDone(wakeDone)
  );

  typedef struct {
    int          due;
    logic [12:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] mk(input logic [2:0] cause, input logic rec,
                                     input logic sl, input logic st, input logic id,
                                     input logic sr, input logic wd);
    return {cause, 1'b0, rec, 3'b000, sl, st, id, sr, wd};
  endfunction

  task automatic expectAt(input int due, input logic [12:0] exp, input string tag);
    item_t it;
    int pos;
    it.due = due; it.exp = exp; it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due > due) begin pos = i; break; end
    end
    q.insert(pos, it);
  endtask

  // monitor: compare outputs at the falling edge
  always @(negedge clk) begin
    logic [12:0] obs;
    obs = {rdData, sleepReq, standbyReq, idleReq, softRst, wakeDone};
    while (q.size() > 0 && q[0].due <= cyc) begin
      nRun++;
      if (q[0].due < cyc || obs !== q[0].exp) begin
        nFail++;
        $display("FAIL %s cycle %0d actual=%h expected=%h", q[0].tag, q[0].due, obs, q[0].exp);
      end
      void'(q.pop_front());
    end
  end

  // drive one cycle of stimulus; base is the cycle count at drive time
  task automatic apply(input logic w, input logic [7:0] d, input logic [4:0] e,
                       input logic k, output int base);
    @(negedge clk);
    wrEn = w; wrData = d; srcEvt = e; wakeEvt = k;
    base = cyc;
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; srcEvt = '0; wakeEvt = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int b, bw;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    b = cyc;
    expectAt(b + 1, mk(3'd0, 0, 0, 0, 0, 0, 0), "R1 reset state");
    quiet(2);

    apply(1, 8'h08, 0, 0, b); expectAt(b + 1, mk(0, 1, 0, 0, 0, 0, 0), "R5 rec set"); quiet(1);
    apply(1, 8'h00, 0, 0, b); expectAt(b + 1, mk(0, 0, 0, 0, 0, 0, 0), "R5 rec clear"); quiet(1);

    apply(1, 8'h01, 0, 0, b); expectAt(b + 1, mk(0, 0, 0, 0, 1, 0, 0), "R6 idle entry"); quiet(1);
    apply(1, 8'h04, 0, 0, b); expectAt(b + 1, mk(0, 0, 0, 0, 1, 0, 0), "R8 write ignored in idle"); quiet(1);
    apply(0, 0, 0, 1, b);
    expectAt(b + 1, mk(0, 0, 0, 0, 0, 0, 1), "R9 idle wake");
    expectAt(b + 2, mk(0, 0, 0, 0, 0, 0, 0), "R9 done single pulse");
    quiet(2);

    apply(1, 8'h0E, 0, 0, b); expectAt(b + 1, mk(0, 1, 1, 0, 0, 0, 0), "R7 sleep over standby"); quiet(1);
    apply(0, 0, 0, 1, b); expectAt(b + 1, mk(0, 1, 0, 0, 0, 0, 1), "R10 fast wake sleep"); quiet(1);
    apply(1, 8'h0B, 0, 0, b); expectAt(b + 1, mk(0, 1, 0, 1, 0, 0, 0), "R7 standby over idle"); quiet(1);
    apply(0, 0, 0, 1, b); expectAt(b + 1, mk(0, 1, 0, 0, 0, 0, 1), "R10 fast wake standby"); quiet(2);

    apply(0, 0, 0, 1, b); expectAt(b + 1, mk(0, 1, 0, 0, 0, 0, 0), "R13 wake while running"); quiet(1);

    apply(1, 8'h04, 0, 0, b); expectAt(b + 1, mk(0, 0, 1, 0, 0, 0, 0), "R6 sleep entry"); quiet(1);
    apply(0, 0, 0, 1, b);
    expectAt(b + 1, mk(0, 0, 0, 0, 0, 0, 0), "R11 request drops, no early done");
    expectAt(b + DLY, mk(0, 0, 0, 0, 0, 0, 0), "R11 done not before interval");
    expectAt(b + DLY + 1, mk(0, 0, 0, 0, 0, 0, 1), "R11 done after interval");
    expectAt(b + DLY + 2, mk(0, 0, 0, 0, 0, 0, 0), "R11 done single pulse");
    quiet(DLY + 3);

    apply(1, 8'h18, 0, 0, b);
    expectAt(b + 1, mk(3'd5, 0, 0, 0, 0, 1, 0), "R4 soft reset pulse and code");
    expectAt(b + 2, mk(3'd5, 0, 0, 0, 0, 0, 0), "R4 soft pulse one cycle");
    quiet(2);

    apply(0, 0, 5'b00100, 0, b);
    expectAt(b + 1, mk(3'd2, 0, 0, 0, 0, 0, 0), "R2 key cause");
    expectAt(b + 2, mk(3'd2, 0, 0, 0, 0, 0, 0), "R2 cause holds");
    quiet(2);
    apply(0, 0, 5'b11000, 0, b); expectAt(b + 1, mk(3'd3, 0, 0, 0, 0, 0, 0), "R3 lowest of two"); quiet(1);
    apply(0, 0, 5'b10001, 0, b); expectAt(b + 1, mk(3'd0, 0, 0, 0, 0, 0, 0), "R3 power-on wins"); quiet(1);
    apply(0, 0, 5'b10000, 0, b); expectAt(b + 1, mk(3'd4, 0, 0, 0, 0, 0, 0), "R2 watchdog cause"); quiet(1);
    apply(1, 8'h10, 5'b00010, 0, b); expectAt(b + 1, mk(3'd1, 0, 0, 0, 0, 1, 0), "R4 external beats soft code"); quiet(1);

    apply(1, 8'h04, 0, 0, b); quiet(0);
    apply(0, 0, 0, 1, bw); quiet(2);
    apply(0, 0, 5'b10000, 0, b); expectAt(b + 1, mk(3'd4, 0, 0, 0, 0, 0, 0), "R12 event during settle");
    expectAt(bw + DLY + 1, mk(3'd4, 0, 0, 0, 0, 0, 0), "R12 settle cancelled, no done");
    quiet(DLY + 2);

    apply(1, 8'h12, 0, 0, b); expectAt(b + 1, mk(3'd5, 0, 0, 0, 0, 1, 0), "R12 soft beats mode write"); quiet(1);
    apply(1, 8'h0A, 0, 0, b); expectAt(b + 1, mk(3'd5, 1, 0, 1, 0, 0, 0), "R6 standby entry"); quiet(1);
    apply(0, 0, 5'b00100, 0, b); expectAt(b + 1, mk(3'd2, 0, 0, 0, 0, 0, 0), "R12 event ends standby"); quiet(2);

    while (q.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule